// File: doc/BRIEF.md
# Receive Electrical Idle Inference Monitor

This block watches one receive lane of a serial-link PHY interface and decides when the far end should be treated as having gone to electrical idle. It works by absence. A 3-bit rule select names a kind of event and a window length. If no such event arrives within the window, the block infers idle entry. Each matching event restarts the window.

The lane supplies one 8-bit symbol per clock, together with a control/data flag and a valid flag. It also supplies a raw electrical-idle level. A speed input chooses between first and second link speed, which changes some window lengths.

The output is a single-cycle pulse. After a pulse the block re-arms at once, so a lane that stays silent produces one pulse per window. Window lengths come from parameters: the clock rate in MHz, the long window in microseconds, and the unit intervals carried by one symbol.

Top module: `rx_idle_infer`

## Requirements
- R1: While inferSel[2] is 0 (select values 0 to 3), idlePulse never asserts, for any speed and any lane activity.
- R2: With inferSel = 3'b100, the event is a valid control symbol 0xBC (rxValid=1, rxIsK=1). This includes the 0xBC that opens a skip set, followed by a valid control symbol 0x1C. The window is CLK_MHZ*WINDOW_US cycles at either speed.
- R3: With inferSel = 3'b101, the event is a training set. It is a valid control 0xBC at symbol index 0, then valid symbols at indices 1 to 5, then a valid data symbol (rxIsK=0) of 0x4A or 0x45 at index 6. The same identifier value at any other index is not an event. The window is 1280/UI_PER_SYM cycles at either speed.
- R4: With inferSel = 3'b110, the event is a falling edge of rxIdle, meaning 1 in one cycle and 0 in the next. The window is 2000/UI_PER_SYM cycles when genSel=0 and 16000/UI_PER_SYM cycles when genSel=1.
- R5: With inferSel = 3'b111 and genSel=0, the event is a falling edge of rxIdle and the window is CLK_MHZ*WINDOW_US cycles. With genSel=1 this rule is inactive and idlePulse never asserts.
- R6: A cycle with rxValid=0 carries no symbol: it is never an event, and it aborts any skip or training set being decoded.
- R7: If a window restarts at clock edge e and no event follows, idlePulse is high for exactly one cycle, set by edge e+L, where L is the active window. The window restarts at that same edge, so a silent lane pulses every L cycles.
- R8: A change of inferSel or genSel restarts the window at the edge where the new value is sampled.
- R9: Synchronous reset clears all state, and idlePulse is low during and after reset. The last reset edge counts as a window restart.
- R10: Events that do not belong to the active rule do not restart the window. Examples are a lone 0xBC under rule 3'b101, a rising edge of rxIdle, and 0xBC with rxIsK=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| inferSel | input | 3 | Inference rule select |
| genSel | input | 1 | Link speed: 0 first, 1 second |
| rxSym | input | 8 | Received symbol |
| rxIsK | input | 1 | Symbol is a control symbol |
| rxValid | input | 1 | Symbol lock and valid symbol |
| rxIdle | input | 1 | Raw receive electrical-idle level |
| idlePulse | output | 1 | One-cycle inferred idle entry |

## Verification
The assertions check four properties on every cycle:
- idlePulse stays low in the disabled and inactive rules, and in the cycle after reset.
- idlePulse never lasts two cycles.
- A 0xBC under the skip rule suppresses the next pulse.
- An invalid cycle leaves no skip or training decode pending.

Exact window lengths for every select and speed pair, the index at which a training identifier counts, and the restart points set by events, config changes and reset are shown only by the bench. It does this by measuring the edge distance to the first pulse and counting the pulses over two windows.

// File: rtl/rx_idle_infer_pkg.sv
package rx_idle_infer_pkg;

  typedef enum logic [1:0] {
    RULE_OFF    = 2'd0,
    RULE_ORDSET = 2'd1,
    RULE_TRAIN  = 2'd2,
    RULE_EXIT   = 2'd3
  } ruleT;

  typedef struct packed {
    logic clear;
    logic incr;
    logic fire;
  } winStrobeT;

  localparam logic [7:0] SYM_COMMA = 8'hBC;
  localparam logic [7:0] SYM_SKIP  = 8'h1C;
  localparam logic [7:0] ID_TRAIN1 = 8'h4A;
  localparam logic [7:0] ID_TRAIN2 = 8'h45;
  localparam int         TRAIN_ID_IDX = 6;

endpackage

// File: rtl/rx_idle_infer_dp.sv
module rx_idle_infer_dp
  import rx_idle_infer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    rxSym,
  input  logic          rxIsK,
  input  logic          rxValid,
  input  logic          rxIdle,
  input  logic [CW-1:0] limit,
  input  winStrobeT     strobe,
  output logic          ordsetHit,
  output logic          trainHit,
  output logic          exitHit,
  output logic          atLast,
  output logic          idlePulse
);

  localparam logic [2:0] ID_IDX = 3'(TRAIN_ID_IDX);

  logic          prevComma;
  logic          prevIdle;
  logic [2:0]    trainIdx;
  logic [CW-1:0] winCnt;
  logic          pulseQ;
  logic          commaNow;
  logic          skipNow;
  logic          idMatch;

  // symbol classification, valid cycles only
  assign commaNow = rxValid && rxIsK && (rxSym == SYM_COMMA);
  assign skipNow  = prevComma && rxValid && rxIsK && (rxSym == SYM_SKIP);
  assign idMatch  = (rxSym == ID_TRAIN1) || (rxSym == ID_TRAIN2);
  assign trainHit = (trainIdx == ID_IDX) && rxValid && !rxIsK && idMatch;
  assign ordsetHit = commaNow || skipNow;
  assign exitHit  = prevIdle && !rxIdle;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevComma <= 1'b0;
      prevIdle  <= 1'b0;
      trainIdx  <= '0;
    end else begin
      prevComma <= commaNow;
      prevIdle  <= rxIdle;
      if (!rxValid) begin
        trainIdx <= '0;
      end else if (commaNow) begin
        trainIdx <= 3'd1;
      end else if (trainIdx == '0 || trainIdx == ID_IDX) begin
        trainIdx <= '0;
      end else begin
        trainIdx <= trainIdx + 3'd1;
      end
    end
  end

  // window counter and pulse register
  assign atLast = (winCnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt <= '0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= strobe.fire;
      if (strobe.clear) begin
        winCnt <= '0;
      end else if (strobe.incr) begin
        winCnt <= winCnt + CW'(1);
      end
    end
  end

  assign idlePulse = pulseQ;

  // R6: an invalid cycle leaves no set decode pending
  a_r6_invalid_aborts: assert property (@(posedge clk) disable iff (rst)
    !rxValid |=> (!trainHit && !skipNow));

endmodule

// File: rtl/rx_idle_infer_ctrl.sv
module rx_idle_infer_ctrl
  import rx_idle_infer_pkg::*;
#(
  parameter int CW      = 16,
  parameter int LIM_OS  = 32000,
  parameter int LIM_TS  = 128,
  parameter int LIM_EX1 = 200,
  parameter int LIM_EX2 = 1600
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    inferSel,
  input  logic          genSel,
  input  logic          ordsetHit,
  input  logic          trainHit,
  input  logic          exitHit,
  input  logic          atLast,
  output logic [CW-1:0] limit,
  output winStrobeT     strobe
);

  logic [3:0] cfgQ;
  logic       cfgChange;
  logic       ruleActive;
  logic       evHit;
  ruleT       rule;

  assign cfgChange = ({inferSel, genSel} != cfgQ);

  always_ff @(posedge clk) begin
    cfgQ <= {inferSel, genSel};
  end

  always_comb begin
    if (!inferSel[2])            rule = RULE_OFF;
    else if (inferSel[1:0] == 2'b00) rule = RULE_ORDSET;
    else if (inferSel[1:0] == 2'b01) rule = RULE_TRAIN;
    else                          rule = RULE_EXIT;
  end

  // the long-window exit rule exists at first speed only
  assign ruleActive = (rule != RULE_OFF) && !(inferSel[1:0] == 2'b11 && genSel);

  always_comb begin
    unique case (rule)
      RULE_ORDSET: limit = CW'(LIM_OS);
      RULE_TRAIN:  limit = CW'(LIM_TS);
      RULE_EXIT: begin
        if (inferSel[0])  limit = CW'(LIM_OS);
        else if (genSel)  limit = CW'(LIM_EX2);
        else              limit = CW'(LIM_EX1);
      end
      default:     limit = CW'(LIM_OS);
    endcase
  end

  always_comb begin
    unique case (rule)
      RULE_ORDSET: evHit = ordsetHit;
      RULE_TRAIN:  evHit = trainHit;
      RULE_EXIT:   evHit = exitHit;
      default:     evHit = 1'b0;
    endcase
  end

  always_comb begin
    strobe.fire  = ruleActive && atLast && !evHit && !cfgChange && !rst;
    strobe.clear = !ruleActive || evHit || cfgChange || strobe.fire;
    strobe.incr  = !strobe.clear;
  end

  // R5: the exit rule at second speed never fires
  a_r5_gen2_exit_off: assert property (@(posedge clk) disable iff (rst)
    (inferSel == 3'b111 && genSel) |-> !strobe.fire);

endmodule

// File: rtl/rx_idle_infer.sv
module rx_idle_infer
  import rx_idle_infer_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int WINDOW_US  = 128,
  parameter int UI_PER_SYM = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] inferSel,
  input  logic       genSel,
  input  logic [7:0] rxSym,
  input  logic       rxIsK,
  input  logic       rxValid,
  input  logic       rxIdle,
  output logic       idlePulse
);

  localparam int LIM_OS  = CLK_MHZ * WINDOW_US;
  localparam int LIM_TS  = 1280 / UI_PER_SYM;
  localparam int LIM_EX1 = 2000 / UI_PER_SYM;
  localparam int LIM_EX2 = 16000 / UI_PER_SYM;
  localparam int MAX_A   = (LIM_OS > LIM_TS) ? LIM_OS : LIM_TS;
  localparam int MAX_B   = (LIM_EX1 > LIM_EX2) ? LIM_EX1 : LIM_EX2;
  localparam int LIM_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] limit;
  winStrobeT     strobe;
  logic          ordsetHit;
  logic          trainHit;
  logic          exitHit;
  logic          atLast;

  rx_idle_infer_ctrl #(
    .CW(CW), .LIM_OS(LIM_OS), .LIM_TS(LIM_TS), .LIM_EX1(LIM_EX1), .LIM_EX2(LIM_EX2)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inferSel(inferSel), .genSel(genSel),
    .ordsetHit(ordsetHit), .trainHit(trainHit), .exitHit(exitHit),
    .atLast(atLast), .limit(limit), .strobe(strobe)
  );

  rx_idle_infer_dp #(.CW(CW)) u_dp (
    .clk(clk), .rst(rst), .rxSym(rxSym), .rxIsK(rxIsK), .rxValid(rxValid),
    .rxIdle(rxIdle), .limit(limit), .strobe(strobe), .ordsetHit(ordsetHit),
    .trainHit(trainHit), .exitHit(exitHit), .atLast(atLast), .idlePulse(idlePulse)
  );

  // R1: disabled rule never yields a pulse
  a_r1_off_silent: assert property (@(posedge clk) disable iff (rst)
    $past(!inferSel[2]) |-> !idlePulse);

  // R7: pulse lasts a single cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    idlePulse |=> !idlePulse);

  // R9: nothing is produced right after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !idlePulse);

  // R2: a comma under the skip rule suppresses the next pulse
  a_r2_comma_restarts: assert property (@(posedge clk) disable iff (rst)
    (inferSel == 3'b100 && rxValid && rxIsK && rxSym == 8'hBC) |=> !idlePulse);

endmodule

// File: tb/rx_idle_infer_bench.sv
module rx_idle_infer_bench;

  localparam int CLK_MHZ = 1;
  localparam int WIN_US  = 40;
  localparam int UIPS    = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] inferSel = 3'b100;
  logic       genSel = 1'b0;
  logic [7:0] rxSym = 8'h00;
  logic       rxIsK = 1'b0;
  logic       rxValid = 1'b1;
  logic       rxIdle = 1'b0;
  logic       idlePulse;

  int edgeCnt = 0;
  int firstPulse = -1;
  int pulseN = 0;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  rx_idle_infer #(.CLK_MHZ(CLK_MHZ), .WINDOW_US(WIN_US), .UI_PER_SYM(UIPS)) u_rx_idle_infer (
    .clk(clk), .rst(rst), .inferSel(inferSel), .genSel(genSel), .rxSym(rxSym),
    .rxIsK(rxIsK), .rxValid(rxValid), .rxIdle(rxIdle), .idlePulse(idlePulse)
  );

  function automatic int expLim(int s, int g);
    if (s < 4) return 0;
    if (s == 4) return CLK_MHZ * WIN_US;
    if (s == 5) return 1280 / UIPS;
    if (s == 6) return (g != 0) ? 16000 / UIPS : 2000 / UIPS;
    return (g != 0) ? 0 : CLK_MHZ * WIN_US;
  endfunction

  function automatic string selTag(int s);
    if (s < 4) return "R1";
    if (s == 4) return "R2";
    if (s == 5) return "R3";
    if (s == 6) return "R4";
    return "R5";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    edgeCnt++;
    #1;
    if (idlePulse) begin
      pulseN++;
      if (firstPulse < 0) firstPulse = edgeCnt;
    end
  endtask

  task automatic arm();
    firstPulse = -1;
    pulseN = 0;
  endtask

  task automatic sendSym(input logic [7:0] s, input logic k, input logic v);
    rxSym = s; rxIsK = k; rxValid = v;
    step();
  endtask

  task automatic quiet(input int n);
    rxSym = 8'h00; rxIsK = 1'b0; rxValid = 1'b1;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic sendTrain(input logic [7:0] id, input int nData);
    sendSym(8'hBC, 1'b1, 1'b1);
    for (int i = 0; i < nData; i++) sendSym(8'h11, 1'b0, 1'b1);
    sendSym(id, 1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", edgeCnt, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int e;
    int r;
    int lim;
    int n;
    // R9: reset, then first window counted from the last reset edge
    arm();
    for (int i = 0; i < 3; i++) step();
    chk(pulseN == 0, "R9 pulse during reset", pulseN, 0);
    rst = 1'b0;
    r = edgeCnt;
    arm();
    quiet(85);
    chk(firstPulse == r + 40, "R9 first pulse edge after reset", firstPulse, r + 40);
    chk(pulseN == 2, "R7 periodic single-cycle pulses", pulseN, 2);

    // R1..R5, R7: sweep every select and speed with a silent lane
    for (int s = 0; s < 8; s++) begin
      for (int g = 0; g < 2; g++) begin
        inferSel = 3'(s);
        genSel = 1'(g);
        step();
        e = edgeCnt;
        arm();
        lim = expLim(s, g);
        n = (lim > 0) ? 2 * lim + 3 : 1700;
        quiet(n);
        if (lim > 0) begin
          chk(firstPulse == e + lim, {selTag(s), " window length"}, firstPulse, e + lim);
          chk(pulseN == 2, "R7 pulse count over two windows", pulseN, 2);
        end else begin
          chk(pulseN == 0, {selTag(s), " inactive rule silent"}, pulseN, 0);
        end
      end
    end

    // R2: comma restarts the window; R6/R10 invalid or data-flagged comma ignored
    inferSel = 3'b100; genSel = 1'b0;
    step();
    quiet(20);
    sendSym(8'hBC, 1'b1, 1'b1);
    e = edgeCnt;
    arm();
    quiet(8);
    sendSym(8'hBC, 1'b1, 1'b0);
    quiet(4);
    sendSym(8'hBC, 1'b0, 1'b1);
    quiet(40);
    chk(firstPulse == e + 40, "R2 comma restart, R6 R10 ignored commas", firstPulse, e + 40);

    // R2: skip set restarts the window
    quiet(5);
    sendSym(8'hBC, 1'b1, 1'b1);
    sendSym(8'h1C, 1'b1, 1'b1);
    e = edgeCnt;
    arm();
    quiet(45);
    chk(firstPulse == e + 40, "R2 skip set restart", firstPulse, e + 40);

    // R8: speed change restarts the window
    quiet(3);
    step();
    quiet(20);
    genSel = 1'b1;
    step();
    e = edgeCnt;
    arm();
    quiet(45);
    chk(firstPulse == e + 40, "R8 config change restart", firstPulse, e + 40);

    // R3: training sets with both identifiers
    inferSel = 3'b101; genSel = 1'b0;
    step();
    quiet(10);
    sendTrain(8'h4A, 5);
    e = edgeCnt;
    arm();
    quiet(20);
    chk(firstPulse < 0, "R3 no pulse early", firstPulse, -1);
    sendTrain(8'h45, 5);
    e = edgeCnt;
    arm();
    // R3/R10: identifier at index 5 and a lone comma do not restart
    quiet(5);
    sendTrain(8'h4A, 4);
    quiet(3);
    sendSym(8'hBC, 1'b1, 1'b1);
    quiet(130);
    chk(firstPulse == e + 128, "R3 id restart, misplaced id and R10 lone comma ignored", firstPulse, e + 128);

    // R6: invalid cycle aborts the training decode
    quiet(2);
    sendSym(8'hBC, 1'b1, 1'b1);
    e = edgeCnt - 3;
    sendSym(8'hBC, 1'b1, 1'b1);
    sendTrain(8'h4A, 5);
    e = edgeCnt;
    arm();
    quiet(5);
    sendSym(8'hBC, 1'b1, 1'b1);
    sendSym(8'h11, 1'b0, 1'b1);
    sendSym(8'h11, 1'b0, 1'b1);
    sendSym(8'h11, 1'b0, 1'b0);
    sendSym(8'h11, 1'b0, 1'b1);
    sendSym(8'h11, 1'b0, 1'b1);
    sendSym(8'h11, 1'b0, 1'b1);
    sendSym(8'h4A, 1'b0, 1'b1);
    quiet(125);
    chk(firstPulse == e + 128, "R6 invalid cycle aborts training set", firstPulse, e + 128);

    // R4: falling edge restarts, R10: rising edge ignored
    inferSel = 3'b110; genSel = 1'b0;
    rxIdle = 1'b1;
    step();
    quiet(10);
    rxIdle = 1'b0;
    step();
    e = edgeCnt;
    arm();
    quiet(30);
    rxIdle = 1'b1;
    step();
    quiet(175);
    chk(firstPulse == e + 200, "R4 falling edge restart, R10 rising ignored", firstPulse, e + 200);

    // R5: long-window exit rule at first speed
    inferSel = 3'b111;
    step();
    quiet(20);
    rxIdle = 1'b0;
    step();
    e = edgeCnt;
    arm();
    quiet(45);
    chk(firstPulse == e + 40, "R5 exit restart at first speed", firstPulse, e + 40);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule